// File: doc/BRIEF.md
# Timer Capture/Compare Channel Controller

This block is one channel of a system timer. It keeps a stored time value and a small configuration word, and it runs a three-state machine: IDLE (unarmed), CAPT (capture) and CMP (compare). In CMP, the block watches the selected view of the running time. When that time equals the stored value, the block raises a one-cycle event, toggles its output bit and returns to IDLE. In CAPT, a qualifying edge on the external input copies the selected time into the stored value and raises an event. After that capture the channel either stays in CAPT or falls back to IDLE, depending on the rearm bit.

Software drives the block through write strobes that share one data bus. The strobes are: a value write, an alias write, a configuration write, and an arm-set or arm-clear write that carries a single data bit. The named transitions are:
- ARM_BY_VALUE: any state to CMP when the value is written.
- ARM_SET: IDLE or CMP to CMP or CAPT, chosen by the mode bit.
- DISARM: any state to IDLE on an arm-clear write.
- MATCH: CMP to IDLE when the selected time equals the stored value.
- CAPTURE_ONE: CAPT to IDLE after a capture with rearm clear.
- CAPTURE_KEEP: CAPT to CAPT after a capture with rearm set.

When two writes land in the same cycle, DISARM wins over ARM_BY_VALUE, and ARM_BY_VALUE wins over ARM_SET. Two copies of the block make a two-channel timer. Only one copy enables the resolution bit.

Top module: `ccarm_channel`

## Requirements
- R1: After reset the channel is unarmed, `evt_pulse` and `out_bit` are 0, and `val_rd` and `cfg_rd` are 0.
- R2: A value write stores `wdata` and arms the channel in compare mode. Both results are visible the cycle after the strobe.
- R3: In compare mode, when the selected time equals the stored value at a clock edge, the block does three things after that edge: `evt_pulse` is 1, `out_bit` is inverted and `armed` is 0. A time that does not equal the value does nothing.
- R4: An arm-set write with `arm_wbit`=0 has no effect. With `arm_wbit`=1 from IDLE or compare, the channel enters capture if the mode bit is 1 and compare if it is 0. The stored value is kept.
- R5: An arm-set write with `arm_wbit`=1 while in capture leaves the state and the stored value unchanged, and raises no event.
- R6: An arm-clear write with `arm_wbit`=1 makes the channel unarmed with no event, and a later time match is then ignored. With `arm_wbit`=0 it has no effect.
- R7: When an arm-clear write coincides with a compare match, the event is still raised and `out_bit` still toggles. The channel ends unarmed.
- R8: An alias write replaces the stored value only. The armed state, the mode and the output bit are unchanged, and the old value no longer matches.
- R9: In capture with rearm=0, a qualifying edge latches the selected time into the value and raises an event. The channel then returns to unarmed, and `out_bit` is not changed.
- R10: In capture with rearm=1, the channel stays armed after each capture, and each later qualifying edge captures again.
- R11: The 2-bit edge field selects the qualifying edge: 2'b11 is rising, 2'b01 is falling, 2'b10 is both edges and 2'b00 is none. An edge that does not qualify causes no capture and no event.
- R12: The configuration word layout is bit 0 mode (1 = capture), bits 2:1 edge select, bit 3 rearm and bit 4 resolution. With `HAS_RES`=1, resolution 1 selects `time_coarse` for both compare and capture, and resolution 0 selects `time_fine`.
- R13: `evt_pulse` is high for exactly one cycle per match or single capture, and only when the channel was armed the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_fine | input | TW | Fine-resolution time view |
| time_coarse | input | TW | Coarse-resolution time view |
| sig_in | input | 1 | External capture input |
| cfg_wr | input | 1 | Configuration write strobe (uses wdata[4:0]) |
| val_wr | input | 1 | Value write strobe, arms compare |
| alias_wr | input | 1 | Alias value write strobe, value only |
| wdata | input | TW | Write data |
| arm_set_wr | input | 1 | Arm-set write strobe |
| arm_clr_wr | input | 1 | Arm-clear write strobe |
| arm_wbit | input | 1 | Data bit carried by arm-set or arm-clear |
| val_rd | output | TW | Stored capture/compare value |
| cfg_rd | output | 5 | Configuration word |
| evt_pulse | output | 1 | One-cycle event |
| out_bit | output | 1 | Output level, toggled on compare match |
| armed | output | 1 | 1 in capture or compare, 0 when unarmed |

## Verification
Compare mode is first run from a vector table. The table covers times one below the stored value and equal to it, an old value after an alias write, and a match while unarmed. Together these separate a true equality from a stale or disabled comparison. Capture is then driven with rising, falling and toggling input patterns under each edge encoding. This shows whether the edge decode picks the right transitions and whether rearm keeps the channel alive. The remaining directed cases cover four situations: a clear landing on a match, an arm-set while capturing, a switch to the coarse time view, and a reset while armed.

// File: rtl/ccarm_pkg.sv
package ccarm_pkg;

    localparam int CFG_W = 5;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_CAPT = 2'd1,
        CH_CMP  = 2'd2
    } ch_state_e;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_RISE = 2'b11
    } edge_sel_e;

    // packed MSB first: res is bit 4, mode is bit 0
    typedef struct packed {
        logic      res;
        logic      rearm;
        edge_sel_e edge_sel;
        logic      capture_mode;
    } ch_cfg_t;

endpackage

// File: rtl/ccarm_cfg_reg.sv
module ccarm_cfg_reg
    import ccarm_pkg::*;
#(
    parameter bit HAS_RES = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] wdata,
    output ch_cfg_t          cfg
);

    logic [CFG_W-1:0] wr_masked;

    generate
        if (HAS_RES) begin : g_res
            assign wr_masked = wdata;
        end else begin : g_nores
            assign wr_masked = {1'b0, wdata[CFG_W-2:0]};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (cfg_wr) begin
            cfg <= ch_cfg_t'(wr_masked);
        end
    end

endmodule

// File: rtl/ccarm_edge_det.sv
module ccarm_edge_det
    import ccarm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sig_in,
    input  edge_sel_e edge_sel,
    output logic      edge_hit
);

    logic sig_q;
    logic rise;
    logic fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_q <= 1'b0;
        end else begin
            sig_q <= sig_in;
        end
    end

    assign rise = sig_in & ~sig_q;
    assign fall = ~sig_in & sig_q;

    always_comb begin
        unique case (edge_sel)
            EDGE_OFF:  edge_hit = 1'b0;
            EDGE_FALL: edge_hit = fall;
            EDGE_BOTH: edge_hit = rise | fall;
            EDGE_RISE: edge_hit = rise;
            default:   edge_hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/ccarm_value_reg.sv
module ccarm_value_reg #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          val_wr,
    input  logic          alias_wr,
    input  logic [TW-1:0] wdata,
    input  logic          cap_load,
    input  logic [TW-1:0] sel_time,
    output logic [TW-1:0] value
);

    // software writes take priority over a capture in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (val_wr || alias_wr) begin
            value <= wdata;
        end else if (cap_load) begin
            value <= sel_time;
        end
    end

endmodule

// File: rtl/ccarm_fsm.sv
module ccarm_fsm
    import ccarm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      val_wr,
    input  logic      arm_set,
    input  logic      arm_clr,
    input  logic      capture_mode,
    input  logic      rearm,
    input  logic      edge_hit,
    input  logic      time_eq,
    output ch_state_e state,
    output logic      cap_load,
    output logic      evt_pulse,
    output logic      out_bit
);

    ch_state_e nxt;
    logic      cmp_hit;
    logic      cap_hit;

    assign cmp_hit  = (state == CH_CMP)  && time_eq;
    assign cap_hit  = (state == CH_CAPT) && edge_hit;
    assign cap_load = cap_hit;

    // next state: DISARM > ARM_BY_VALUE > ARM_SET > event transitions
    always_comb begin
        nxt = state;
        if (arm_clr) begin
            nxt = CH_IDLE;
        end else if (val_wr) begin
            nxt = CH_CMP;
        end else if (arm_set && (state != CH_CAPT)) begin
            nxt = capture_mode ? CH_CAPT : CH_CMP;
        end else begin
            unique case (state)
                CH_IDLE: nxt = CH_IDLE;
                CH_CAPT: nxt = (cap_hit && !rearm) ? CH_IDLE : CH_CAPT;
                CH_CMP:  nxt = cmp_hit ? CH_IDLE : CH_CMP;
                default: nxt = CH_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CH_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_pulse <= 1'b0;
            out_bit   <= 1'b0;
        end else begin
            evt_pulse <= cmp_hit | cap_hit;
            if (cmp_hit) begin
                out_bit <= ~out_bit;
            end
        end
    end

endmodule

// File: rtl/ccarm_channel.sv
module ccarm_channel
    import ccarm_pkg::*;
#(
    parameter int TW      = 32,
    parameter bit HAS_RES = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TW-1:0]    time_fine,
    input  logic [TW-1:0]    time_coarse,
    input  logic             sig_in,
    input  logic             cfg_wr,
    input  logic             val_wr,
    input  logic             alias_wr,
    input  logic [TW-1:0]    wdata,
    input  logic             arm_set_wr,
    input  logic             arm_clr_wr,
    input  logic             arm_wbit,
    output logic [TW-1:0]    val_rd,
    output logic [CFG_W-1:0] cfg_rd,
    output logic             evt_pulse,
    output logic             out_bit,
    output logic             armed
);

    ch_cfg_t   cfg;
    ch_state_e state;
    logic      edge_hit;
    logic      cap_load;
    logic      time_eq;
    logic [TW-1:0] sel_time;
    logic [TW-1:0] value;

    ccarm_cfg_reg #(.HAS_RES(HAS_RES)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_wr (cfg_wr),
        .wdata  (wdata[CFG_W-1:0]),
        .cfg    (cfg)
    );

    generate
        if (HAS_RES) begin : g_tsel
            assign sel_time = cfg.res ? time_coarse : time_fine;
        end else begin : g_tfix
            assign sel_time = time_fine;
        end
    endgenerate

    ccarm_edge_det u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig_in   (sig_in),
        .edge_sel (cfg.edge_sel),
        .edge_hit (edge_hit)
    );

    ccarm_value_reg #(.TW(TW)) u_val (
        .clk      (clk),
        .rst_n    (rst_n),
        .val_wr   (val_wr),
        .alias_wr (alias_wr),
        .wdata    (wdata),
        .cap_load (cap_load),
        .sel_time (sel_time),
        .value    (value)
    );

    assign time_eq = (sel_time == value);

    ccarm_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .val_wr       (val_wr),
        .arm_set      (arm_set_wr & arm_wbit),
        .arm_clr      (arm_clr_wr & arm_wbit),
        .capture_mode (cfg.capture_mode),
        .rearm        (cfg.rearm),
        .edge_hit     (edge_hit),
        .time_eq      (time_eq),
        .state        (state),
        .cap_load     (cap_load),
        .evt_pulse    (evt_pulse),
        .out_bit      (out_bit)
    );

    assign val_rd = value;
    assign cfg_rd = cfg;
    assign armed  = (state != CH_IDLE);

endmodule

// File: rtl/ccarm_channel_chk.sv
module ccarm_channel_chk #(
    parameter int TW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          val_wr,
    input logic          alias_wr,
    input logic [TW-1:0] wdata,
    input logic          arm_set_wr,
    input logic          arm_clr_wr,
    input logic          arm_wbit,
    input logic [TW-1:0] val_rd,
    input logic          evt_pulse,
    input logic          out_bit,
    input logic          armed
);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!armed && !evt_pulse && !out_bit && val_rd == '0));

    p_valwr_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (val_wr && !arm_clr_wr) |=> (armed && val_rd == $past(wdata)));

    p_out_needs_evt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && out_bit != $past(out_bit)) |-> evt_pulse);

    p_set_zero_noop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_set_wr && !arm_wbit && !val_wr && !arm_clr_wr && !armed) |=> !armed);

    p_clr_disarms_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_clr_wr && arm_wbit) |=> !armed);

    p_alias_keeps_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (alias_wr && !val_wr && !arm_set_wr && !arm_clr_wr)
            |=> ((armed == $past(armed)) || evt_pulse));

    p_evt_from_armed_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && evt_pulse) |-> $past(armed));

endmodule

bind ccarm_channel ccarm_channel_chk #(.TW(TW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .val_wr     (val_wr),
    .alias_wr   (alias_wr),
    .wdata      (wdata),
    .arm_set_wr (arm_set_wr),
    .arm_clr_wr (arm_clr_wr),
    .arm_wbit   (arm_wbit),
    .val_rd     (val_rd),
    .evt_pulse  (evt_pulse),
    .out_bit    (out_bit),
    .armed      (armed)
);

// File: tb/ccarm_channel_tb_top.sv
`timescale 1ns/1ps
module ccarm_channel_tb_top;

    localparam int TW = 32;

    localparam logic [2:0] OP_NOP   = 3'd0;
    localparam logic [2:0] OP_VAL   = 3'd1;
    localparam logic [2:0] OP_ASET  = 3'd2;
    localparam logic [2:0] OP_ACLR  = 3'd3;
    localparam logic [2:0] OP_ALIAS = 3'd4;
    localparam logic [2:0] OP_CFG   = 3'd5;

    typedef struct packed {
        logic [2:0]  op;
        logic        wb;
        logic [31:0] data;
        logic [31:0] tf;
        logic        e_armed;
        logic        e_evt;
        logic        e_out;
        logic [31:0] e_val;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{OP_NOP,   1'b0, 32'd0,  32'd0,  1'b0, 1'b0, 1'b0, 32'd0 },  // R1 idle
        '{OP_VAL,   1'b0, 32'd10, 32'd0,  1'b1, 1'b0, 1'b0, 32'd10},  // R2 arm by value
        '{OP_NOP,   1'b0, 32'd0,  32'd9,  1'b1, 1'b0, 1'b0, 32'd10},  // R3 no match
        '{OP_NOP,   1'b0, 32'd0,  32'd10, 1'b0, 1'b1, 1'b1, 32'd10},  // R3 match
        '{OP_NOP,   1'b0, 32'd0,  32'd10, 1'b0, 1'b0, 1'b1, 32'd10},  // R13 single pulse
        '{OP_ASET,  1'b0, 32'd0,  32'd3,  1'b0, 1'b0, 1'b1, 32'd10},  // R4 bit 0 no effect
        '{OP_ASET,  1'b1, 32'd0,  32'd3,  1'b1, 1'b0, 1'b1, 32'd10},  // R4 enter compare
        '{OP_ALIAS, 1'b0, 32'd20, 32'd3,  1'b1, 1'b0, 1'b1, 32'd20},  // R8 value only
        '{OP_NOP,   1'b0, 32'd0,  32'd10, 1'b1, 1'b0, 1'b1, 32'd20},  // R8 old value dead
        '{OP_ACLR,  1'b0, 32'd0,  32'd4,  1'b1, 1'b0, 1'b1, 32'd20},  // R6 bit 0 no effect
        '{OP_ACLR,  1'b1, 32'd0,  32'd5,  1'b0, 1'b0, 1'b1, 32'd20},  // R6 disarm
        '{OP_NOP,   1'b0, 32'd0,  32'd20, 1'b0, 1'b0, 1'b1, 32'd20},  // R6 match ignored
        '{OP_ALIAS, 1'b0, 32'd30, 32'd0,  1'b0, 1'b0, 1'b1, 32'd30},  // R8 stays unarmed
        '{OP_VAL,   1'b0, 32'd40, 32'd0,  1'b1, 1'b0, 1'b1, 32'd40},  // R2 rearm
        '{OP_NOP,   1'b0, 32'd0,  32'd40, 1'b0, 1'b1, 1'b0, 32'd40}   // R3 toggle back
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] time_fine = '0;
    logic [TW-1:0] time_coarse = '0;
    logic          sig_in = 1'b0;
    logic          cfg_wr = 1'b0;
    logic          val_wr = 1'b0;
    logic          alias_wr = 1'b0;
    logic [TW-1:0] wdata = '0;
    logic          arm_set_wr = 1'b0;
    logic          arm_clr_wr = 1'b0;
    logic          arm_wbit = 1'b0;
    logic [TW-1:0] val_rd;
    logic [4:0]    cfg_rd;
    logic          evt_pulse;
    logic          out_bit;
    logic          armed;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ccarm_channel #(.TW(TW), .HAS_RES(1'b1)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .time_fine   (time_fine),
        .time_coarse (time_coarse),
        .sig_in      (sig_in),
        .cfg_wr      (cfg_wr),
        .val_wr      (val_wr),
        .alias_wr    (alias_wr),
        .wdata       (wdata),
        .arm_set_wr  (arm_set_wr),
        .arm_clr_wr  (arm_clr_wr),
        .arm_wbit    (arm_wbit),
        .val_rd      (val_rd),
        .cfg_rd      (cfg_rd),
        .evt_pulse   (evt_pulse),
        .out_bit     (out_bit),
        .armed       (armed)
    );

    // called at a falling edge; returns one cycle later at the next falling edge
    task automatic go(input logic [2:0] op, input logic wb, input logic [31:0] d,
                      input logic [31:0] tf, input logic [31:0] tc, input logic s);
        time_fine   = tf;
        time_coarse = tc;
        sig_in      = s;
        wdata       = d;
        arm_wbit    = wb;
        val_wr      = (op == OP_VAL);
        alias_wr    = (op == OP_ALIAS);
        arm_set_wr  = (op == OP_ASET);
        arm_clr_wr  = (op == OP_ACLR);
        cfg_wr      = (op == OP_CFG);
        @(negedge clk);
        val_wr = 1'b0; alias_wr = 1'b0; arm_set_wr = 1'b0;
        arm_clr_wr = 1'b0; cfg_wr = 1'b0; arm_wbit = 1'b0;
    endtask

    task automatic chk(input string tag, input logic a, input logic e,
                       input logic o, input logic [31:0] v);
        total++;
        if (armed !== a || evt_pulse !== e || out_bit !== o || val_rd !== v) begin
            bad++;
            $display("FAIL %s: armed/evt/out/val got %b/%b/%b/%0d expected %b/%b/%b/%0d",
                     tag, armed, evt_pulse, out_bit, val_rd, a, e, o, v);
        end
    endtask

    task automatic chk_cfg(input string tag, input logic [4:0] c);
        total++;
        if (cfg_rd !== c) begin
            bad++;
            $display("FAIL %s: cfg got %b expected %b", tag, cfg_rd, c);
        end
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish, got hang expected end");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset", 1'b0, 1'b0, 1'b0, 32'd0);
        chk_cfg("R1 cfg reset", 5'd0);

        // compare-mode vector table
        for (int i = 0; i < NV; i++) begin
            go(VECS[i].op, VECS[i].wb, VECS[i].data, VECS[i].tf, 32'd0, 1'b0);
            chk($sformatf("table row %0d", i), VECS[i].e_armed, VECS[i].e_evt,
                VECS[i].e_out, VECS[i].e_val);
        end

        // R7: clear coinciding with a match
        go(OP_VAL, 1'b0, 32'd50, 32'd0, 32'd0, 1'b0);
        chk("R2 arm 50", 1'b1, 1'b0, 1'b0, 32'd50);
        go(OP_ACLR, 1'b1, 32'd0, 32'd50, 32'd0, 1'b0);
        chk("R7 clear plus match", 1'b0, 1'b1, 1'b1, 32'd50);

        // R9: one-shot rising capture (cfg 00111)
        go(OP_CFG, 1'b0, 32'd7, 32'd0, 32'd0, 1'b0);
        chk_cfg("R12 cfg layout", 5'b00111);
        go(OP_ASET, 1'b1, 32'd0, 32'd0, 32'd0, 1'b0);
        chk("R4 enter capture", 1'b1, 1'b0, 1'b1, 32'd50);
        go(OP_NOP, 1'b0, 32'd0, 32'd77, 32'd0, 1'b1);
        chk("R9 one-shot capture", 1'b0, 1'b1, 1'b1, 32'd77);

        // R10/R5: rearmed rising capture (cfg 01111)
        go(OP_CFG, 1'b0, 32'd15, 32'd0, 32'd0, 1'b0);
        go(OP_NOP, 1'b0, 32'd0, 32'd0, 32'd0, 1'b0);
        chk("R11 fall ignored unarmed", 1'b0, 1'b0, 1'b1, 32'd77);
        go(OP_ASET, 1'b1, 32'd0, 32'd0, 32'd0, 1'b0);
        go(OP_ASET, 1'b1, 32'd0, 32'd5, 32'd0, 1'b0);
        chk("R5 set in capture", 1'b1, 1'b0, 1'b1, 32'd77);
        go(OP_NOP, 1'b0, 32'd0, 32'd100, 32'd0, 1'b1);
        chk("R10 first capture", 1'b1, 1'b1, 1'b1, 32'd100);
        go(OP_NOP, 1'b0, 32'd0, 32'd101, 32'd0, 1'b0);
        chk("R11 rising ignores fall", 1'b1, 1'b0, 1'b1, 32'd100);
        go(OP_NOP, 1'b0, 32'd0, 32'd102, 32'd0, 1'b1);
        chk("R10 second capture", 1'b1, 1'b1, 1'b1, 32'd102);

        // R11: falling (01011), both (01101), none (01001)
        go(OP_CFG, 1'b0, 32'd11, 32'd0, 32'd0, 1'b1);
        go(OP_NOP, 1'b0, 32'd0, 32'd200, 32'd0, 1'b0);
        chk("R11 falling edge", 1'b1, 1'b1, 1'b1, 32'd200);
        go(OP_NOP, 1'b0, 32'd0, 32'd201, 32'd0, 1'b1);
        chk("R11 falling ignores rise", 1'b1, 1'b0, 1'b1, 32'd200);
        go(OP_CFG, 1'b0, 32'd13, 32'd0, 32'd0, 1'b1);
        go(OP_NOP, 1'b0, 32'd0, 32'd300, 32'd0, 1'b0);
        chk("R11 both on fall", 1'b1, 1'b1, 1'b1, 32'd300);
        go(OP_NOP, 1'b0, 32'd0, 32'd301, 32'd0, 1'b1);
        chk("R11 both on rise", 1'b1, 1'b1, 1'b1, 32'd301);
        go(OP_CFG, 1'b0, 32'd9, 32'd0, 32'd0, 1'b1);
        go(OP_NOP, 1'b0, 32'd0, 32'd400, 32'd0, 1'b0);
        chk("R11 none", 1'b1, 1'b0, 1'b1, 32'd301);

        // R12: coarse view for capture (11111) and compare (10000)
        go(OP_CFG, 1'b0, 32'd31, 32'd0, 32'd0, 1'b0);
        chk_cfg("R12 res bit", 5'b11111);
        go(OP_NOP, 1'b0, 32'd0, 32'd500, 32'd7, 1'b1);
        chk("R12 coarse capture", 1'b1, 1'b1, 1'b1, 32'd7);
        go(OP_CFG, 1'b0, 32'd16, 32'd0, 32'd0, 1'b1);
        go(OP_VAL, 1'b0, 32'd9, 32'd0, 32'd0, 1'b1);
        go(OP_NOP, 1'b0, 32'd0, 32'd9, 32'd0, 1'b1);
        chk("R12 fine ignored", 1'b1, 1'b0, 1'b1, 32'd9);
        go(OP_NOP, 1'b0, 32'd0, 32'd0, 32'd9, 1'b1);
        chk("R12 coarse match", 1'b0, 1'b1, 1'b0, 32'd9);

        // R1: reset while armed
        go(OP_VAL, 1'b0, 32'd5, 32'd0, 32'd0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset while armed", 1'b0, 1'b0, 1'b0, 32'd0);
        chk_cfg("R1 cfg cleared", 5'd0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule